// File: doc/BRIEF.md
# Multi-Channel Register-Window DMA Engine

This block copies blocks of bytes between a 24-bit source address space and a 256-byte window of video-chip registers at 0x2100–0x21FF, and holds the CPU stalled while it does so. It has eight channels. Software programs each one through a small write-only register bank. Each channel holds a control byte, a destination register offset, a 24-bit source address and a 16-bit length. Writing a channel mask to the start register launches every selected channel. The CPU halt output stays high until the last selected channel has moved its final byte.

Channels are serviced one after another, lowest number first. One halt cycle before each channel loads its byte counter, and after that one byte moves per clock. The memory bus and the register-window bus are simple single-cycle buses with combinational read data. On every transfer cycle one side is read and the other side is written in that same cycle. A channel's source address register keeps the value it has advanced to, so a later start of the same channel continues from where the last one stopped.

Top module: `dma_mmio_top`

## Requirements
- R1: Configuration writes use cfg_addr. When bit 6 is 0, bits [5:3] select the channel and bits [2:0] select the register: 0 is control, 1 is the destination offset, 2, 3 and 4 are source bits [7:0], [15:8] and [23:16], and 5 and 6 are length bits [7:0] and [15:8]. Register 7 and every address from 0x41 to 0x7F are ignored. Address 0x40 is the start mask, where bit n selects channel n.
- R2: Writing a nonzero start mask while idle raises cpu_halt on the next cycle. Writing a zero mask leaves cpu_halt low and the buses quiet.
- R3: Every register-window access uses vid_addr[15:8] = 0x21. The low byte is the channel's destination offset plus the pattern offset, taken modulo 256.
- R4: Control bits [1:0] select the pattern. 0 and 3 write the same register every cycle. 1 uses each source byte on two consecutive cycles at the same register. 2 alternates between offset and offset+1, starting at offset.
- R5: Control bits [3:2] select the source step applied after each source advance: 0 is +1, 1 is +32, 2 is +0 and 3 is −1. The source address wraps modulo 2^24.
- R6: Control bit 7 selects the direction. At 0, memory is read (mem_we=0) and its data is written to the register window (vid_we=1). At 1, the window is read and its data is written to memory at the source address.
- R7: Selected channels run in ascending channel order. Each one has exactly one halt cycle without bus activity before its first byte, and its mask bit clears when it finishes.
- R8: The length counts bus transfer cycles, whatever the pattern. A length of 0 means 65536 cycles.
- R9: cpu_halt falls on the cycle right after the last byte of the last selected channel. When cpu_halt is low, mem_req and vid_req are low.
- R10: A channel's source address register keeps its advanced value after the channel finishes.
- R11: After reset, cpu_halt, mem_req and vid_req are low and no channel is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_halt | output | 1 | CPU stall request |
| mem_req | output | 1 | Memory bus access this cycle |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, same cycle |
| vid_req | output | 1 | Register-window access this cycle |
| vid_we | output | 1 | Register-window write (1) or read (0) |
| vid_addr | output | 16 | Register-window address |
| vid_wdata | output | 8 | Register-window write data |
| vid_rdata | input | 8 | Register-window read data, same cycle |

## Verification
The bench drives transfers in both directions and tries every pattern and step code. Within one start it mixes odd and even lengths. The repeat pattern and the pair pattern are the ones that tell apart the source advance cadence from the destination offset cadence. An odd-length pair transfer, a destination offset of 0xFF and a source address next to 2^24 expose wrap errors in the two address adders. Multi-channel masks with gaps between the selected bits check the service order and the load cycle between channels. A repeated start without reprogramming shows whether the source register was written back. A zero length with a held source address exercises the full 65536-cycle count.

// File: rtl/dma_pkg.sv
package dma_pkg;
  parameter int SRC_W  = 24;
  parameter int LEN_W  = 16;
  parameter int DATA_W = 8;

  typedef enum logic [1:0] {
    PAT_ONE   = 2'd0,
    PAT_TWICE = 2'd1,
    PAT_PAIR  = 2'd2,
    PAT_ONE_B = 2'd3
  } pat_e;

  typedef enum logic [1:0] {
    STEP_INC1  = 2'd0,
    STEP_INC32 = 2'd1,
    STEP_HOLD  = 2'd2,
    STEP_DEC1  = 2'd3
  } step_e;

  typedef struct packed {
    logic              to_mem;
    pat_e              pat;
    step_e             step;
    logic [7:0]        dest;
    logic [SRC_W-1:0]  src;
    logic [LEN_W-1:0]  len;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOAD = 2'd1,
    SQ_XFER = 2'd2
  } seq_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [2:0]        wr_reg,
  input  logic [7:0]        wr_data,
  input  logic              adv_en,
  input  logic [CH_W-1:0]   adv_chan,
  input  logic [SRC_W-1:0]  adv_src,
  output chan_cfg_t         cfg_o [NUM_CH]
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    chan_cfg_t cur_q, cur_n;
    logic      hit, adv_hit;

    assign hit     = wr_en  && (wr_chan  == CH_W'(g));
    assign adv_hit = adv_en && (adv_chan == CH_W'(g));

    always_comb begin
      cur_n = cur_q;
      if (hit) begin
        case (wr_reg)
          3'd0: begin
            cur_n.to_mem = wr_data[7];
            cur_n.step   = step_e'(wr_data[3:2]);
            cur_n.pat    = pat_e'(wr_data[1:0]);
          end
          3'd1: cur_n.dest       = wr_data;
          3'd2: cur_n.src[7:0]   = wr_data;
          3'd3: cur_n.src[15:8]  = wr_data;
          3'd4: cur_n.src[23:16] = wr_data;
          3'd5: cur_n.len[7:0]   = wr_data;
          3'd6: cur_n.len[15:8]  = wr_data;
          default: ;
        endcase
      end
      if (adv_hit) cur_n.src = adv_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cur_q <= '0;
      else if (hit || adv_hit) cur_q <= cur_n;
    end

    assign cfg_o[g] = cur_q;
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NUM_CH-1:0] start_mask,
  input  logic [LEN_W-1:0]  pick_len,
  output logic [CH_W-1:0]   pick_ch,
  output logic [CH_W-1:0]   cur_ch,
  output logic              xfer,
  output logic              phase,
  output logic              halt,
  output logic [NUM_CH-1:0] en_mask
);

  seq_e              st_q, st_n;
  logic [NUM_CH-1:0] en_q, en_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              ph_q, ph_n;
  logic [CH_W-1:0]   cur_q, cur_n;
  logic              step_en;

  // lowest selected channel wins
  always_comb begin
    pick_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (en_q[i]) pick_ch = CH_W'(i);
    end
  end

  always_comb begin
    st_n  = st_q;
    en_n  = en_q;
    cnt_n = cnt_q;
    ph_n  = ph_q;
    cur_n = cur_q;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          en_n = start_mask;
          st_n = SQ_LOAD;
        end
      end
      SQ_LOAD: begin
        cur_n = pick_ch;
        cnt_n = (pick_len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, pick_len};
        ph_n  = 1'b0;
        st_n  = SQ_XFER;
      end
      SQ_XFER: begin
        cnt_n = cnt_q - CNT_W'(1);
        ph_n  = ~ph_q;
        if (cnt_q == CNT_W'(1)) begin
          en_n = en_q & ~(NUM_CH'(1) << cur_q);
          st_n = (en_n != '0) ? SQ_LOAD : SQ_IDLE;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  assign step_en = (st_q != SQ_IDLE) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      en_q  <= '0;
      cnt_q <= '0;
      ph_q  <= 1'b0;
      cur_q <= '0;
    end else if (step_en) begin
      st_q  <= st_n;
      en_q  <= en_n;
      cnt_q <= cnt_n;
      ph_q  <= ph_n;
      cur_q <= cur_n;
    end
  end

  assign cur_ch  = cur_q;
  assign xfer    = (st_q == SQ_XFER);
  assign phase   = ph_q;
  assign halt    = (st_q != SQ_IDLE);
  assign en_mask = en_q;

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_pkg::*;
(
  input  pat_e              pat,
  input  step_e             step,
  input  logic [7:0]        dest,
  input  logic [SRC_W-1:0]  src,
  input  logic              phase,
  output logic [7:0]        vid_lo,
  output logic              advance,
  output logic [SRC_W-1:0]  next_src
);

  logic off;

  assign off     = (pat == PAT_PAIR) ? phase : 1'b0;
  assign vid_lo  = dest + {7'd0, off};
  assign advance = (pat == PAT_TWICE) ? phase : 1'b1;

  always_comb begin
    case (step)
      STEP_INC1:  next_src = src + SRC_W'(1);
      STEP_INC32: next_src = src + SRC_W'(32);
      STEP_HOLD:  next_src = src;
      default:    next_src = src - SRC_W'(1);
    endcase
  end

endmodule

// File: rtl/dma_mmio_top.sv
module dma_mmio_top
  import dma_pkg::*;
#(
  parameter int         NUM_CH = 8,
  parameter logic [7:0] VID_HI = 8'h21,
  localparam int        CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [6:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic              cpu_halt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [SRC_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              vid_req,
  output logic              vid_we,
  output logic [15:0]       vid_addr,
  output logic [DATA_W-1:0] vid_wdata,
  input  logic [DATA_W-1:0] vid_rdata
);

  logic              rs0_q, rst_q;
  chan_cfg_t         cfg [NUM_CH];
  logic              ch_wr, en_wr, start;
  logic [CH_W-1:0]   pick_ch, cur_ch;
  logic              xfer, phase, halt;
  logic [NUM_CH-1:0] en_mask;
  logic [7:0]        vid_lo;
  logic              advance;
  logic [SRC_W-1:0]  next_src;

  // reset synchroniser: assert asynchronously, release on clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rst_q <= rs0_q;
    end
  end

  assign ch_wr = cfg_we && !cfg_addr[6] && !halt;
  assign en_wr = cfg_we && (cfg_addr == 7'h40);
  assign start = en_wr && !halt && (cfg_wdata[NUM_CH-1:0] != '0);

  dma_chan_regs #(.NUM_CH(NUM_CH)) regs_i (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_en    (ch_wr),
    .wr_chan  (cfg_addr[3 +: CH_W]),
    .wr_reg   (cfg_addr[2:0]),
    .wr_data  (cfg_wdata),
    .adv_en   (xfer && advance),
    .adv_chan (cur_ch),
    .adv_src  (next_src),
    .cfg_o    (cfg)
  );

  dma_seq #(.NUM_CH(NUM_CH)) seq_i (
    .clk        (clk),
    .rst_n      (rst_q),
    .start      (start),
    .start_mask (cfg_wdata[NUM_CH-1:0]),
    .pick_len   (cfg[pick_ch].len),
    .pick_ch    (pick_ch),
    .cur_ch     (cur_ch),
    .xfer       (xfer),
    .phase      (phase),
    .halt       (halt),
    .en_mask    (en_mask)
  );

  dma_addr_gen agen_i (
    .pat      (cfg[cur_ch].pat),
    .step     (cfg[cur_ch].step),
    .dest     (cfg[cur_ch].dest),
    .src      (cfg[cur_ch].src),
    .phase    (phase),
    .vid_lo   (vid_lo),
    .advance  (advance),
    .next_src (next_src)
  );

  assign cpu_halt  = halt;
  assign mem_req   = xfer;
  assign vid_req   = xfer;
  assign mem_we    = xfer &&  cfg[cur_ch].to_mem;
  assign vid_we    = xfer && !cfg[cur_ch].to_mem;
  assign mem_addr  = cfg[cur_ch].src;
  assign vid_addr  = {VID_HI, vid_lo};
  assign vid_wdata = mem_rdata;
  assign mem_wdata = vid_rdata;

endmodule

// File: rtl/dma_mmio_chk.sv
module dma_mmio_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_q,
  input logic              cpu_halt,
  input logic              mem_req,
  input logic              mem_we,
  input logic              vid_req,
  input logic              vid_we,
  input logic [7:0]        vid_hi,
  input logic              cfg_we,
  input logic [6:0]        cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic [NUM_CH-1:0] en_mask
);

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !cpu_halt |-> (!mem_req && !vid_req)); // R9

  AST_VID_WINDOW: assert property (@(posedge clk) disable iff (!rst_q)
    vid_req |-> (vid_hi == 8'h21)); // R3

  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_q)
    mem_req |-> (vid_req && (mem_we != vid_we))); // R6

  AST_START_HALTS: assert property (@(posedge clk) disable iff (!rst_q)
    (!cpu_halt && cfg_we && cfg_addr == 7'h40 && cfg_wdata[NUM_CH-1:0] != '0) |=> cpu_halt); // R2

  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_q)
    (!cpu_halt && cfg_we && cfg_addr == 7'h40 && cfg_wdata[NUM_CH-1:0] == '0) |=> !cpu_halt); // R2

  AST_MASK_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_q)
    cpu_halt |=> ((en_mask & ~$past(en_mask)) == '0)); // R7

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(cpu_halt) |-> (en_mask == '0)); // R7

endmodule

bind dma_mmio_top dma_mmio_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk       (clk),
  .rst_q     (rst_q),
  .cpu_halt  (cpu_halt),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .vid_req   (vid_req),
  .vid_we    (vid_we),
  .vid_hi    (vid_addr[15:8]),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .en_mask   (en_mask)
);

// File: tb/dma_mmio_top_tb_top.sv
module dma_mmio_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [6:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        cpu_halt, mem_req, mem_we, vid_req, vid_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, vid_wdata, vid_rdata;
  logic [15:0] vid_addr;

  always #5 clk = ~clk;

  dma_mmio_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cpu_halt(cpu_halt), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .vid_req(vid_req), .vid_we(vid_we),
    .vid_addr(vid_addr), .vid_wdata(vid_wdata), .vid_rdata(vid_rdata)
  );

  function automatic logic [7:0] mem_fn(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] vid_fn(logic [15:0] a);
    logic [7:0] r;
    r = a[7:0] * 8'd3 + 8'd1;
    return r;
  endfunction

  assign mem_rdata = mem_fn(mem_addr);
  assign vid_rdata = vid_fn(vid_addr);

  typedef struct {
    bit        busy;
    bit        mwe;
    bit [23:0] maddr;
    bit [15:0] vaddr;
    bit [7:0]  data;
    string     tag;
  } exp_t;

  exp_t      q[$];
  bit [7:0]  m_ctrl [8];
  bit [7:0]  m_dest [8];
  bit [23:0] m_src  [8];
  bit [15:0] m_len  [8];
  int        vectors = 0;
  int        errors  = 0;
  int        cyc     = 0;
  bit        run_mon = 0;

  task automatic fail(string tag, string what, longint act, longint expv);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
  endtask

  // per-cycle comparison against the reference queue
  always @(negedge clk) begin
    if (run_mon) begin
      exp_t e;
      vectors++;
      if (q.size() > 0) begin
        e = q.pop_front();
        if (cpu_halt !== 1'b1) fail(e.tag, "cpu_halt", cpu_halt, 1);
        if (!e.busy) begin
          if (mem_req !== 1'b0 || vid_req !== 1'b0)
            fail(e.tag, "load-cycle req", {mem_req, vid_req}, 0);
        end else begin
          if (mem_req !== 1'b1 || vid_req !== 1'b1)
            fail(e.tag, "req", {mem_req, vid_req}, 3);
          if (mem_we !== e.mwe)   fail(e.tag, "mem_we", mem_we, e.mwe);
          if (vid_we !== !e.mwe)  fail(e.tag, "vid_we", vid_we, !e.mwe);
          if (mem_addr !== e.maddr) fail(e.tag, "mem_addr", mem_addr, e.maddr);
          if (vid_addr !== e.vaddr) fail(e.tag, "vid_addr", vid_addr, e.vaddr);
          if (e.mwe) begin
            if (mem_wdata !== e.data) fail(e.tag, "mem_wdata", mem_wdata, e.data);
          end else begin
            if (vid_wdata !== e.data) fail(e.tag, "vid_wdata", vid_wdata, e.data);
          end
        end
      end else begin
        // R9: idle means no halt and quiet buses
        if (cpu_halt !== 1'b0) fail("R9", "cpu_halt idle", cpu_halt, 0);
        if (mem_req !== 1'b0 || vid_req !== 1'b0)
          fail("R9", "idle req", {mem_req, vid_req}, 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic cfg_write(logic [6:0] a, logic [7:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (!a[6]) begin
      case (a[2:0])
        3'd0: m_ctrl[a[5:3]] = d;
        3'd1: m_dest[a[5:3]] = d;
        3'd2: m_src[a[5:3]][7:0]   = d;
        3'd3: m_src[a[5:3]][15:8]  = d;
        3'd4: m_src[a[5:3]][23:16] = d;
        3'd5: m_len[a[5:3]][7:0]   = d;
        3'd6: m_len[a[5:3]][15:8]  = d;
        default: ;
      endcase
    end
  endtask

  task automatic prog(int c, bit [7:0] ctrl, bit [7:0] dest, bit [23:0] src, bit [15:0] len);
    cfg_write(7'(c * 8 + 0), ctrl);
    cfg_write(7'(c * 8 + 1), dest);
    cfg_write(7'(c * 8 + 2), src[7:0]);
    cfg_write(7'(c * 8 + 3), src[15:8]);
    cfg_write(7'(c * 8 + 4), src[23:16]);
    cfg_write(7'(c * 8 + 5), len[7:0]);
    cfg_write(7'(c * 8 + 6), len[15:8]);
  endtask

  task automatic gen(int c, string tag);
    int       n;
    bit [1:0] pat, st;
    bit       tm, adv;
    exp_t     e;
    n   = (m_len[c] == 0) ? 65536 : int'(m_len[c]);
    pat = m_ctrl[c][1:0];
    st  = m_ctrl[c][3:2];
    tm  = m_ctrl[c][7];
    e.busy = 0; e.mwe = 0; e.maddr = 0; e.vaddr = 0; e.data = 0; e.tag = "R7";
    q.push_back(e);
    for (int i = 0; i < n; i++) begin
      bit [7:0] off;
      off     = (pat == 2'd2) ? 8'(i % 2) : 8'd0;
      e.busy  = 1;
      e.mwe   = tm;
      e.maddr = m_src[c];
      e.vaddr = {8'h21, 8'(m_dest[c] + off)};
      e.data  = tm ? vid_fn(e.vaddr) : mem_fn(e.maddr);
      e.tag   = tag;
      q.push_back(e);
      adv = (pat == 2'd1) ? (i % 2 == 1) : 1'b1;
      if (adv) begin
        case (st)
          2'd0: m_src[c] = m_src[c] + 24'd1;
          2'd1: m_src[c] = m_src[c] + 24'd32;
          2'd2: ;
          default: m_src[c] = m_src[c] - 24'd1;
        endcase
      end
    end
  endtask

  task automatic start(bit [7:0] mask, string tag);
    cfg_write(7'h40, mask);
    for (int c = 0; c < 8; c++) if (mask[c]) gen(c, tag);
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int i = 0; i < 8; i++) begin
      m_ctrl[i] = 0; m_dest[i] = 0; m_src[i] = 0; m_len[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    vectors++;
    if (cpu_halt !== 1'b0 || mem_req !== 1'b0 || vid_req !== 1'b0)
      fail("R11", "reset outputs", {cpu_halt, mem_req, vid_req}, 0);
    run_mon = 1;

    // R2: zero mask does nothing
    cfg_write(7'h40, 8'h00);
    repeat (3) @(negedge clk);

    // R1 R3 R4 R5 R6: single pattern, +1, memory to window
    prog(0, 8'h00, 8'h18, 24'h123456, 16'd5);
    start(8'h01, "R4");

    // R4 R5 R7: repeat pattern +32 on ch2, pair pattern -1 with dest wrap on ch5
    prog(2, 8'h05, 8'h04, 24'h00FFF0, 16'd6);
    prog(5, 8'h0E, 8'hFF, 24'h000001, 16'd5);
    start(8'h24, "R5");

    // R6 R5: window to memory, hold and source wrap past 2^24
    prog(3, 8'h8A, 8'h30, 24'hABCDEF, 16'd4);
    prog(7, 8'h83, 8'h40, 24'hFFFFFE, 16'd4);
    start(8'h88, "R6");

    // R1: register 7 and unused addresses are ignored
    cfg_write(7'h07, 8'hFF);
    cfg_write(7'h41, 8'hFF);
    cfg_write(7'h7F, 8'h01);
    repeat (3) @(negedge clk);

    // R10 R7: restart without reprogramming, gapped mask
    start(8'hA5, "R10");

    // R8: length zero means 65536 cycles
    prog(1, 8'h08, 8'h22, 24'h004000, 16'd0);
    start(8'h02, "R8");

    run_mon = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule